// File: doc/BRIEF.md
# Banked Edge-Interrupt GPIO Controller

This block gives software control of general-purpose pins arranged as banks of 32. Each pin can be an output driven from a latch or an input. Its level is always visible through a two-stage synchronizer. Each pin can also raise an interrupt on a rising edge, a falling edge, or both.

All access goes through a simple 32-bit register bus with a combinational read path. Software changes output bits and edge enables through paired write-one set and write-one clear ports, so no read-modify-write is needed. Captured edges collect in a per-bank status word that software clears by writing ones.

Each 16-pin half of a bank drives one level interrupt line. A global enable register gates each of these lines.

Top module: `gpio_edge_banks`

## Requirements
- R1: After reset every direction bit is 1, so `pinOe` is all zero. The output latches, edge enables, status words, the global enable register and `irqOut` are all zero.
- R2: Bank b occupies ten 32-bit words starting at 0x10 + 0x28*b. The words at offsets 0x00 to 0x24 from that base are, in order:
  - direction
  - output latch
  - set-data
  - clear-data
  - input
  - set-rise
  - clear-rise
  - set-fall
  - clear-fall
  - status

  Reads behave as follows:
  - The set-data and clear-data words read back the output latch.
  - The set-rise and clear-rise words read back the rising-enable mask.
  - The set-fall and clear-fall words read back the falling-enable mask.

  The global enable register is at 0x08. Its bit 2b+h gates half h of bank b.
- R3: A direction bit of 1 makes the pin an input (`pinOe` low). A direction bit of 0 makes it an output (`pinOe` high). In both cases `pinOut` carries the output latch.
- R4: Writing a mask to set-data sets the masked latch bits, and writing to clear-data clears them. Latch bits under zero mask bits keep their value.
- R5: The input word shows each pin's level two clocks after the pin changes, whether the pin is an input or an output.
- R6: Rising and falling enables are independent per pin. Each has its own write-one set port and write-one clear port.
- R7: The status bit of a pin sets on the third clock after the pin changes if the matching edge enable is 1. A change with the matching enable at 0 leaves the status bit at 0.
- R8: Writing 1 to a status bit clears it, and 0 bits leave it unchanged. If an edge lands on a bit in the same clock as a clear of that bit, the bit stays set.
- R9: Interrupt line 2b+h is high when any status bit in half h of bank b is set and bit 2b+h of the global enable register is 1. Half 0 is bits 15:0 and half 1 is bits 31:16.
- R10: Reads of addresses outside the mapped words return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address of the register word |
| busWe | input | 1 | Write strobe for the current address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| pinIn | input | 64 | Pin levels, bank 0 in bits 31:0 |
| pinOut | output | 64 | Output latch values |
| pinOe | output | 64 | Output enable, high for output pins |
| irqOut | output | 4 | Half-bank interrupt lines |

## Verification
A wrong latch or direction bit shows on `pinOut` or `pinOe` on the clock after the offending write. A broken synchronizer shows as the input word changing one clock too early or too late. A wrong enable, status or clear-priority bit shows in the status word exactly three clocks after the pin toggles. It then shows on the interrupt line of that half-bank in the same cycle.

The bench therefore reads every word at exact clock offsets from each pin change. It checks both the "not yet" values and the "now" values, and compares the interrupt lines against the enable mask after every status change.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int BANK_W = 32;
  localparam int HALF_W = 16;
  localparam int HALVES = BANK_W / HALF_W;
  localparam int WSEL_W = 4;

  typedef enum logic [WSEL_W-1:0] {
    W_DIR   = 4'd0,
    W_OUT   = 4'd1,
    W_SET   = 4'd2,
    W_CLR   = 4'd3,
    W_IN    = 4'd4,
    W_SRISE = 4'd5,
    W_CRISE = 4'd6,
    W_SFALL = 4'd7,
    W_CFALL = 4'd8,
    W_STAT  = 4'd9
  } wordSel_e;

  typedef struct packed {
    logic wrDir;
    logic wrOut;
    logic setOut;
    logic clrOut;
    logic setRise;
    logic clrRise;
    logic setFall;
    logic clrFall;
    logic clrStat;
  } bankStrobe_t;

endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int ADDR_W      = 12,
  parameter int BANK0_BASE  = 16,
  parameter int BANK_STRIDE = 40,
  parameter int GLOBAL_ADDR = 8,
  localparam int NUM_IRQ    = NUM_BANKS * HALVES
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWe,
  input  logic [NUM_IRQ-1:0]          enData,
  output bankStrobe_t [NUM_BANKS-1:0] strobes,
  output logic [NUM_BANKS-1:0]        rdHit,
  output logic [WSEL_W-1:0]           rdWord,
  output logic                        rdGlobal,
  output logic [NUM_IRQ-1:0]          bankEn
);

  localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(BANK_STRIDE);
  localparam logic [ADDR_W-1:0] GLOBAL_A = ADDR_W'(GLOBAL_ADDR);

  always_comb begin
    logic [ADDR_W-1:0] baseA;
    logic [ADDR_W-1:0] offs;
    logic              hit;
    logic [WSEL_W-1:0] idx;
    strobes = '0;
    rdHit   = '0;
    rdWord  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      baseA = ADDR_W'(BANK0_BASE + b * BANK_STRIDE);
      offs  = busAddr - baseA;
      hit   = (busAddr >= baseA) && (offs < STRIDE_A) && (busAddr[1:0] == 2'b00);
      idx   = offs[2 +: WSEL_W];
      rdHit[b] = hit;
      if (hit) rdWord = idx;
      if (hit && busWe) begin
        case (wordSel_e'(idx))
          W_DIR:   strobes[b].wrDir   = 1'b1;
          W_OUT:   strobes[b].wrOut   = 1'b1;
          W_SET:   strobes[b].setOut  = 1'b1;
          W_CLR:   strobes[b].clrOut  = 1'b1;
          W_SRISE: strobes[b].setRise = 1'b1;
          W_CRISE: strobes[b].clrRise = 1'b1;
          W_SFALL: strobes[b].setFall = 1'b1;
          W_CFALL: strobes[b].clrFall = 1'b1;
          W_STAT:  strobes[b].clrStat = 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign rdGlobal = (busAddr == GLOBAL_A);

  always_ff @(posedge clk) begin
    if (!rstN) bankEn <= '0;
    else if (busWe && rdGlobal) bankEn <= enData;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes)) else $error("more than one strobe"); // R2

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdHit, rdGlobal})) else $error("address decodes twice"); // R2

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && rdGlobal) |=> bankEn == $past(enData)) else $error("enable write lost"); // R9

endmodule

// File: rtl/gpio_edge_bank_dp.sv
module gpio_edge_bank_dp
  import gpio_edge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strb,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] pinIn,
  input  logic [WSEL_W-1:0] rdWord,
  output logic [BANK_W-1:0] pinOut,
  output logic [BANK_W-1:0] pinOe,
  output logic [BANK_W-1:0] statQ,
  output logic [BANK_W-1:0] rdData
);

  logic [BANK_W-1:0] dirQ, outQ, riseEn, fallEn;
  logic [BANK_W-1:0] syncA, syncB, prevQ;
  logic [BANK_W-1:0] edgeHits;

  assign edgeHits = (syncB & ~prevQ & riseEn) | (~syncB & prevQ & fallEn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ   <= '1;
      outQ   <= '0;
      riseEn <= '0;
      fallEn <= '0;
      statQ  <= '0;
    end else begin
      if (strb.wrDir) dirQ <= wdata;
      if (strb.wrOut)       outQ <= wdata;
      else if (strb.setOut) outQ <= outQ | wdata;
      else if (strb.clrOut) outQ <= outQ & ~wdata;
      if (strb.setRise)      riseEn <= riseEn | wdata;
      else if (strb.clrRise) riseEn <= riseEn & ~wdata;
      if (strb.setFall)      fallEn <= fallEn | wdata;
      else if (strb.clrFall) fallEn <= fallEn & ~wdata;
      statQ <= (statQ & ~(strb.clrStat ? wdata : '0)) | edgeHits;
    end
  end

  assign pinOut = outQ;
  assign pinOe  = ~dirQ;

  always_comb begin
    case (wordSel_e'(rdWord))
      W_DIR:                 rdData = dirQ;
      W_OUT, W_SET, W_CLR:   rdData = outQ;
      W_IN:                  rdData = syncB;
      W_SRISE, W_CRISE:      rdData = riseEn;
      W_SFALL, W_CFALL:      rdData = fallEn;
      W_STAT:                rdData = statQ;
      default:               rdData = '0;
    endcase
  end

  AST_SET_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strb.setOut |=> (outQ & $past(wdata)) == $past(wdata)) else $error("set lost"); // R4

  AST_CLR_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrOut |=> (outQ & $past(wdata)) == '0) else $error("clear lost"); // R4

  AST_KEEP_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setOut || strb.clrOut) |=> (outQ & ~$past(wdata)) == ($past(outQ) & ~$past(wdata)))
    else $error("unmasked latch bit moved"); // R4

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (edgeHits != '0) |=> (statQ & $past(edgeHits)) == $past(edgeHits))
    else $error("edge dropped"); // R8

  AST_STAT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (statQ & ~$past(statQ) & ~$past(riseEn | fallEn)) == '0)
    else $error("status set without enable"); // R7

endmodule

// File: rtl/gpio_edge_banks.sv
module gpio_edge_banks
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 12,
  localparam int PIN_W    = NUM_BANKS * BANK_W,
  localparam int NUM_IRQ  = NUM_BANKS * HALVES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [BANK_W-1:0]  busWdata,
  output logic [BANK_W-1:0]  busRdata,
  input  logic [PIN_W-1:0]   pinIn,
  output logic [PIN_W-1:0]   pinOut,
  output logic [PIN_W-1:0]   pinOe,
  output logic [NUM_IRQ-1:0] irqOut
);

  bankStrobe_t [NUM_BANKS-1:0] strobes;
  logic [NUM_BANKS-1:0]        rdHit;
  logic [WSEL_W-1:0]           rdWord;
  logic                        rdGlobal;
  logic [NUM_IRQ-1:0]          bankEn;
  logic [BANK_W-1:0]           bankRd [NUM_BANKS];
  logic [BANK_W-1:0]           bankStat [NUM_BANKS];

  gpio_edge_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W)
  ) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .enData  (busWdata[NUM_IRQ-1:0]),
    .strobes (strobes),
    .rdHit   (rdHit),
    .rdWord  (rdWord),
    .rdGlobal(rdGlobal),
    .bankEn  (bankEn)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_edge_bank_dp dp (
      .clk   (clk),
      .rstN  (rstN),
      .strb  (strobes[b]),
      .wdata (busWdata),
      .pinIn (pinIn[b*BANK_W +: BANK_W]),
      .rdWord(rdWord),
      .pinOut(pinOut[b*BANK_W +: BANK_W]),
      .pinOe (pinOe[b*BANK_W +: BANK_W]),
      .statQ (bankStat[b]),
      .rdData(bankRd[b])
    );
    for (genvar h = 0; h < HALVES; h++) begin : g_half
      assign irqOut[b*HALVES + h] =
        (|bankStat[b][h*HALF_W +: HALF_W]) & bankEn[b*HALVES + h];
    end
  end

  always_comb begin
    busRdata = '0;
    if (rdGlobal) busRdata = BANK_W'(bankEn);
    for (int b = 0; b < NUM_BANKS; b++)
      if (rdHit[b]) busRdata = bankRd[b];
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & ~bankEn) == '0) else $error("ungated interrupt"); // R9

endmodule

// File: tb/gpio_edge_banks_test.sv
`timescale 1ns/1ps
module gpio_edge_banks_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] pinIn = '0;
  logic [63:0] pinOut, pinOe;
  logic [3:0]  irqOut;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 0;
  logic rdPend = 1'b0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  gpio_edge_banks uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  // monitor: pops expected read data and compares
  always @(negedge clk) begin
    if (rdPend && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (busRdata !== e) begin
        nBad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", t, busAddr, busRdata, e);
      end
    end
  end

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    busAddr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    rdPend = 1'b1;
    @(negedge clk); #1;
    rdPend = 1'b0;
  endtask

  task automatic sigCheck(input logic [63:0] act, input logic [63:0] e, input string t);
    nChecks++;
    if (act !== e) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  task automatic setPins(input logic [63:0] v);
    @(posedge clk); #1;
    pinIn = v;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    nChecks++;
    nBad++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    sigCheck(pinOe, 64'h0, "R1 pinOe");
    sigCheck(pinOut, 64'h0, "R1 pinOut");
    sigCheck({60'h0, irqOut}, 64'h0, "R1 irq");
    busRead(12'h010, 32'hFFFF_FFFF, "R1 dir0");
    busRead(12'h014, 32'h0, "R1 out0");
    busRead(12'h034, 32'h0, "R1 stat0");
    busRead(12'h04C, 32'h0, "R1 rise1");
    busRead(12'h008, 32'h0, "R1 bankEn");

    // R10 unmapped reads
    busRead(12'h000, 32'h0, "R10 0x00");
    busRead(12'h00C, 32'h0, "R10 0x0C");
    busRead(12'h060, 32'h0, "R10 0x60");
    busRead(12'h012, 32'h0, "R10 unaligned");

    // R3 direction, R2 bank separation
    busWrite(12'h010, 32'hFFFF_0000);
    sigCheck(pinOe, 64'h0000_0000_0000_FFFF, "R3 pinOe");
    busWrite(12'h038, 32'h0000_FFFF);
    busRead(12'h038, 32'h0000_FFFF, "R2 dir1");
    busRead(12'h010, 32'hFFFF_0000, "R2 dir0 kept");
    busWrite(12'h014, 32'h1234_5678);
    sigCheck(pinOut, 64'h0000_0000_1234_5678, "R3 pinOut");

    // R4 set/clear data
    busWrite(12'h018, 32'hF000_0000);
    busRead(12'h014, 32'hF234_5678, "R4 set");
    busWrite(12'h01C, 32'h0000_0078);
    busRead(12'h018, 32'hF234_5600, "R4 clear via set port read");
    busRead(12'h01C, 32'hF234_5600, "R2 clear port read");
    sigCheck(pinOut, 64'h0000_0000_F234_5600, "R4 pinOut");

    // R5 synchronized readback, includes output pins
    setPins(64'h0000_0000_A5A5_A5A5);
    busRead(12'h020, 32'h0, "R5 one clock");
    busRead(12'h020, 32'hA5A5_A5A5, "R5 two clocks");
    busRead(12'h034, 32'h0, "R7 no enable no status");

    // R6 edge enables
    busWrite(12'h04C, 32'h0000_00FF);
    busWrite(12'h054, 32'h0000_0F0F);
    busWrite(12'h050, 32'h0000_0003);
    busRead(12'h04C, 32'h0000_00FC, "R6 rise");
    busRead(12'h050, 32'h0000_00FC, "R6 rise via clear port");
    busRead(12'h054, 32'h0000_0F0F, "R6 fall independent");

    // R7 edge timing: bit4 rise on, bit0 rise off
    setPins(64'h0000_0011_A5A5_A5A5);
    busRead(12'h05C, 32'h0, "R7 after 1");
    busRead(12'h05C, 32'h0, "R7 after 2");
    busRead(12'h05C, 32'h0000_0010, "R7 after 3");
    setPins(64'h0000_0000_A5A5_A5A5);
    repeat (2) @(posedge clk);
    busRead(12'h05C, 32'h0000_0011, "R7 falling bit0 only");
    sigCheck({60'h0, irqOut}, 64'h0, "R9 gated off");

    // R9 gating
    busWrite(12'h008, 32'h0000_0004);
    sigCheck({60'h0, irqOut}, 64'h4, "R9 bank1 low half");
    busWrite(12'h008, 32'h0000_0008);
    sigCheck({60'h0, irqOut}, 64'h0, "R9 other half empty");
    busWrite(12'h008, 32'h0000_000F);
    busRead(12'h008, 32'h0000_000F, "R2 bankEn read");

    // R8 write one to clear
    busWrite(12'h05C, 32'h0000_0010);
    busRead(12'h05C, 32'h0000_0001, "R8 partial clear");
    sigCheck({60'h0, irqOut}, 64'h4, "R9 still pending");
    busWrite(12'h05C, 32'h0000_0001);
    busRead(12'h05C, 32'h0, "R8 full clear");
    sigCheck({60'h0, irqOut}, 64'h0, "R9 dropped");

    // R8 edge wins over same-cycle clear
    setPins(64'h0000_0010_A5A5_A5A5);
    @(posedge clk);
    busWrite(12'h05C, 32'h0000_0010);
    busRead(12'h05C, 32'h0000_0010, "R8 edge wins");

    // R9 high half of bank1
    busWrite(12'h04C, 32'h0010_0000);
    setPins(64'h0010_0010_A5A5_A5A5);
    repeat (3) @(posedge clk);
    #1;
    sigCheck({60'h0, irqOut}, 64'hC, "R9 both halves");
    busRead(12'h05C, 32'h0010_0010, "R7 high half status");
    busRead(12'h034, 32'h0, "R7 bank0 untouched");

    finish();
  end

endmodule